// File: doc/BRIEF.md
# Power-Event Status and Wake Router

This block collects power-management events from five PCI Express port groups into one 32-bit status word and routes enabled events to the platform. A status bit goes to 1 when its port group delivers a PME message, or when the processor sends an assert-PME-GPE message for that source. Software clears a bit by writing 1 to it. The block refuses the clear while an assert-PME-GPE condition for that source is still open, that is, until the matching deassert message has arrived.

A second word, with the same bit layout, holds one enable per source. An event is live when its status bit and its enable bit are both 1. Any live event raises a wake request. In the working power state a live event also drives a level-triggered SCI, or drives an SMI instead, depending on two routing controls.

Both words are reached through a small register window with one address bit. The read data is combinational.

Top module: `pme_wake_router`

## Requirements
- R1: After reset, both the status word and the enable word read 0, and the wake, SCI and SMI outputs are low.
- R2: A one-cycle pulse on `pme_msg[i]` sets source i's status bit. The bit is visible on the clock edge that samples the pulse. Sources 0, 1, 2, 3 and 4 map to bit positions 0, 1, 2, 3 and 7 of both words.
- R3: A pulse on `gpe_assert[i]` sets source i's status bit and marks source i as assert-pending. A pulse on `gpe_deassert[i]` removes that mark. If both pulses arrive in the same cycle, the source stays assert-pending.
- R4: A write to address 0 (status) clears each status bit whose data bit is 1, provided that source is not assert-pending. Data bits that are 0 leave their status bits unchanged.
- R5: A clear write to an assert-pending source leaves its status bit set. A deassert that arrives in the same cycle as the write does not allow that write to clear the bit. A later write does clear it.
- R6: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends at 1.
- R7: Bits 6:4 and 31:8 read as 0 at both addresses, and writes to them are ignored.
- R8: A write to address 1 loads the enable word. A write to address 0 never changes the enable word, and a write to address 1 never changes the status word.
- R9: `wake_req` is 1 exactly when some source has both its status bit and its enable bit at 1. This holds in every power state.
- R10: `sci` equals `wake_req` AND `working` AND `sci_en`. The output stays high as long as a live event remains uncleared.
- R11: `smi` equals `wake_req` AND `working` AND NOT `sci_en` AND `smi_en`. `sci` and `smi` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pme_msg | input | 5 | Per-source PME message received pulse |
| gpe_assert | input | 5 | Per-source assert-PME-GPE message pulse |
| gpe_deassert | input | 5 | Per-source deassert-PME-GPE message pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| working | input | 1 | System is in the working power state |
| sci_en | input | 1 | Route live events to SCI |
| smi_en | input | 1 | Global SMI enable |
| wake_req | output | 1 | Wake event request |
| sci | output | 1 | Level-triggered SCI |
| smi | output | 1 | SMI request |

## Verification
The cases that matter are the ones where a hardware event and a software clear of status land in the same clock cycle. These cases are a set colliding with a one-to-clear write, and a deassert message arriving together with the write that depends on it. Directed steps line up each pair on one edge, and the bench checks the read-back status against the rules "set wins" and "the deassert must come first". A long pseudo-random run then scatters pulses and writes so that these coincidences recur on every source. A cycle model built from the requirements judges the read data and all three outputs.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int NSRC = 5;
  localparam int DW   = 32;

  // bit position of source i inside a 32-bit word: 0..3 direct, then 7
  function automatic int src_pos(input int i);
    return (i < 4) ? i : i + 3;
  endfunction

  function automatic logic [DW-1:0] to_word(input logic [NSRC-1:0] v);
    logic [DW-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[src_pos(i)] = v[i];
    return w;
  endfunction

  function automatic logic [NSRC-1:0] from_word(input logic [DW-1:0] w);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = w[src_pos(i)];
    return v;
  endfunction

  typedef enum logic {SEL_STS = 1'b0, SEL_EN = 1'b1} reg_sel_e;
endpackage

// File: rtl/pme_status_cell.sv
module pme_status_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pme,
  input  logic asrt,
  input  logic deas,
  input  logic clr_req,
  output logic sts,
  output logic pend,
  output logic set_hit,
  output logic clr_ok
);
  assign set_hit = pme | asrt;
  // clear honoured only when no assert message is outstanding (registered flag)
  assign clr_ok  = clr_req & ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (set_hit)     sts <= 1'b1;
      else if (clr_ok) sts <= 1'b0;
      if (asrt)        pend <= 1'b1;
      else if (deas)   pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pme_reg_window.sv
module pme_reg_window
  import pwr_evt_pkg::*;
#(
  parameter int NUM_SRC = NSRC,
  parameter int DATA_W  = DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] sts_vec,
  output logic [NUM_SRC-1:0] en_vec,
  output logic [NUM_SRC-1:0] clr_req,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic               sel_en;
  logic [NUM_SRC-1:0] wr_bits;

  assign sel_en  = (reg_addr == SEL_EN);
  assign wr_bits = from_word(reg_wdata);
  assign clr_req = (reg_wr && !sel_en) ? wr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               en_vec <= '0;
    else if (reg_wr && sel_en) en_vec <= wr_bits;
  end

  assign reg_rdata = sel_en ? to_word(en_vec) : to_word(sts_vec);
endmodule

// File: rtl/pme_event_router.sv
module pme_event_router #(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] sts_vec,
  input  logic [NUM_SRC-1:0] en_vec,
  input  logic               working,
  input  logic               sci_en,
  input  logic               smi_en,
  output logic               wake_req,
  output logic               sci,
  output logic               smi
);
  logic live;
  assign live     = |(sts_vec & en_vec);
  assign wake_req = live;
  assign sci      = live & working & sci_en;
  assign smi      = live & working & ~sci_en & smi_en;
endmodule

// File: rtl/pme_wake_router.sv
module pme_wake_router
  import pwr_evt_pkg::*;
#(
  parameter int NUM_SRC = NSRC,
  parameter int DATA_W  = DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pme_msg,
  input  logic [NUM_SRC-1:0] gpe_assert,
  input  logic [NUM_SRC-1:0] gpe_deassert,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               working,
  input  logic               sci_en,
  input  logic               smi_en,
  output logic               wake_req,
  output logic               sci,
  output logic               smi
);
  // named internal events, observed by the bound checker
  logic [NUM_SRC-1:0] sts_q, pend_q, en_q, set_hit, clr_req, clr_ok;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    pme_status_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .pme     (pme_msg[g]),
      .asrt    (gpe_assert[g]),
      .deas    (gpe_deassert[g]),
      .clr_req (clr_req[g]),
      .sts     (sts_q[g]),
      .pend    (pend_q[g]),
      .set_hit (set_hit[g]),
      .clr_ok  (clr_ok[g])
    );
  end

  pme_reg_window #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sts_vec   (sts_q),
    .en_vec    (en_q),
    .clr_req   (clr_req),
    .reg_rdata (reg_rdata)
  );

  pme_event_router #(.NUM_SRC(NUM_SRC)) u_route (
    .sts_vec  (sts_q),
    .en_vec   (en_q),
    .working  (working),
    .sci_en   (sci_en),
    .smi_en   (smi_en),
    .wake_req (wake_req),
    .sci      (sci),
    .smi      (smi)
  );
endmodule

// File: rtl/pme_wake_checker.sv
module pme_wake_checker
  import pwr_evt_pkg::*;
#(
  parameter int NUM_SRC = NSRC,
  parameter int DATA_W  = DW
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] sts_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] set_hit,
  input logic [NUM_SRC-1:0] clr_req,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               working,
  input logic               sci_en,
  input logic               wake_req,
  input logic               sci,
  input logic               smi
);
  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit != '0) |=> ((sts_q & $past(set_hit)) == $past(set_hit)));
  // R5
  refused_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & pend_q & sts_q) != '0) |=>
      ((sts_q & $past(clr_req & pend_q & sts_q)) == $past(clr_req & pend_q & sts_q)));
  // R4
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & ~pend_q & ~set_hit) != '0) |=>
      ((sts_q & $past(clr_req & ~pend_q & ~set_hit)) == '0));
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~to_word('1)) == '0);
  // R11
  sci_smi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sci && smi));
  // R10
  sci_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (wake_req && working && sci_en));
endmodule

bind pme_wake_router pme_wake_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sts_q     (sts_q),
  .pend_q    (pend_q),
  .set_hit   (set_hit),
  .clr_req   (clr_req),
  .reg_rdata (reg_rdata),
  .working   (working),
  .sci_en    (sci_en),
  .wake_req  (wake_req),
  .sci       (sci),
  .smi       (smi)
);

// File: tb/pme_wake_router_bench.sv
module pme_wake_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  pme_msg = '0, gpe_assert = '0, gpe_deassert = '0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        working = 1'b0, sci_en = 1'b0, smi_en = 1'b0;
  logic        wake_req, sci, smi;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // bench's own model state, source-indexed
  logic [4:0] m_sts = '0, m_pend = '0, m_en = '0;

  always #10 clk = ~clk;

  pme_wake_router u_pme_wake_router (
    .clk(clk), .rst_n(rst_n), .pme_msg(pme_msg), .gpe_assert(gpe_assert),
    .gpe_deassert(gpe_deassert), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .working(working),
    .sci_en(sci_en), .smi_en(smi_en), .wake_req(wake_req), .sci(sci), .smi(smi)
  );

  function automatic logic [31:0] place(input logic [4:0] v);
    return {24'd0, v[4], 3'b000, v[3:0]};
  endfunction

  function automatic logic [4:0] pick(input logic [31:0] w);
    return {w[7], w[3:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    logic w;
    w = |(m_sts & m_en);
    chk({tag, " R9 wake"}, {31'd0, wake_req}, {31'd0, w});
    chk({tag, " R10 sci"}, {31'd0, sci}, {31'd0, w & working & sci_en});
    chk({tag, " R11 smi"}, {31'd0, smi}, {31'd0, w & working & ~sci_en & smi_en});
  endtask

  // apply current inputs for one edge, advance model, sample 1 ns after edge
  task automatic step();
    logic [4:0] clr, nsts, npend;
    clr = (reg_wr && !reg_addr) ? pick(reg_wdata) : '0;
    for (int i = 0; i < 5; i++) begin
      if (pme_msg[i] || gpe_assert[i]) nsts[i] = 1'b1;
      else if (clr[i] && !m_pend[i])   nsts[i] = 1'b0;
      else                             nsts[i] = m_sts[i];
      if (gpe_assert[i])        npend[i] = 1'b1;
      else if (gpe_deassert[i]) npend[i] = 1'b0;
      else                      npend[i] = m_pend[i];
    end
    if (reg_wr && reg_addr) m_en = pick(reg_wdata);
    m_sts = nsts;
    m_pend = npend;
    @(posedge clk);
    #1;
    pme_msg = '0; gpe_assert = '0; gpe_deassert = '0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(1'b0, d); chk("R1 status", d, 32'h0);
    rd(1'b1, d); chk("R1 enable", d, 32'h0);
    working = 1'b1; sci_en = 1'b1; smi_en = 1'b1; #1;
    chk_out("R1");

    // R2 each source via PME message, at its bit position
    for (int i = 0; i < 5; i++) begin
      pme_msg = 5'b1 << i; step();
      rd(1'b0, d); chk("R2 pme set", d, place(5'b1 << i));
      wr(1'b0, place(5'b1 << i));
      rd(1'b0, d); chk("R4 clear", d, 32'h0);
    end

    // R4 writing zero does nothing
    pme_msg = 5'h1F; step();
    wr(1'b0, 32'h0);
    rd(1'b0, d); chk("R4 write-0 no effect", d, 32'h8F);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R4 clear all", d, 32'h0);

    // R3/R5 assert message holds off the clear
    gpe_assert = 5'b00100; step();
    rd(1'b0, d); chk("R3 assert sets", d, 32'h4);
    wr(1'b0, 32'h4);
    rd(1'b0, d); chk("R5 refused", d, 32'h4);
    gpe_deassert = 5'b00100; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h4; step();
    rd(1'b0, d); chk("R5 same-cycle deassert refused", d, 32'h4);
    wr(1'b0, 32'h4);
    rd(1'b0, d); chk("R5 clear after deassert", d, 32'h0);
    // R3 assert and deassert together: stays pending
    gpe_assert = 5'b10000; gpe_deassert = 5'b10000; step();
    wr(1'b0, 32'h80);
    rd(1'b0, d); chk("R3 simultaneous stays pending", d, 32'h80);
    gpe_deassert = 5'b10000; step();
    wr(1'b0, 32'h80);
    rd(1'b0, d); chk("R3 released", d, 32'h0);

    // R6 set wins over clear
    pme_msg = 5'b00010; step();
    pme_msg = 5'b00010; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h2; step();
    rd(1'b0, d); chk("R6 set wins", d, 32'h2);

    // R7 / R8 reserved bits and address separation
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); chk("R7 enable reserved", d, 32'h8F);
    rd(1'b0, d); chk("R8 status untouched by enable write", d, 32'h2);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b1, d); chk("R8 enable untouched by status write", d, 32'h8F);
    rd(1'b0, d); chk("R7 status reserved", d, 32'h0);

    // R9-R11 exhaustive routing sweep with all status bits set
    pme_msg = 5'h1F; step();
    for (int e = 0; e < 32; e++) begin
      wr(1'b1, place(e[4:0]));
      for (int c = 0; c < 8; c++) begin
        working = c[0]; sci_en = c[1]; smi_en = c[2]; #1;
        chk_out("sweep");
      end
    end
    // R10 level: SCI holds until the live bit is cleared
    working = 1'b1; sci_en = 1'b1; wr(1'b1, 32'h1); wr(1'b0, 32'h0);
    repeat (3) step();
    chk("R10 level held", {31'd0, sci}, 32'd1);
    wr(1'b0, 32'h1);
    chk("R10 drops on clear", {31'd0, sci}, 32'd0);

    // random phase: model against read data and outputs
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      pme_msg      = (r[3:0] == 0) ? 5'($urandom) : '0;
      gpe_assert   = (r[7:4] == 0) ? 5'($urandom) : '0;
      gpe_deassert = (r[11:8] < 3) ? 5'($urandom) : '0;
      reg_wr       = (r[13:12] == 0);
      reg_addr     = r[14];
      reg_wdata    = $urandom;
      working = r[15]; sci_en = r[16]; smi_en = r[17];
      begin
        logic a;
        a = reg_addr;
        step();
        reg_addr = a; #1;
        chk("R4 R5 R6 random read", reg_rdata, a ? place(m_en) : place(m_sts));
        chk_out("random");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule